// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital controller for a 10-bit successive-approximation converter inside a microcontroller. Software sees three registers on a small synchronous bus: a control register, an input-select register and a read-only result register. A conversion starts either from software, by setting the run and enable bits, or from a rising edge on an external trigger pin. Each conversion takes a fixed number of clock cycles. It begins with a sampling window. A bit-by-bit search then drives a trial code to the analog side and reads back a single comparator decision. The remaining cycles are settling time.

At the end of a conversion the block loads the result register and pulses an interrupt. Several events can collide with that load, and the block resolves them by fixed rules. A CPU read of the result register is served first, and the load follows one cycle later. A write to the control or select register wins outright and cancels both the load and the interrupt. A trigger edge that arrives while a conversion is running is dropped. The analog comparator is outside the block and is represented by the `cmp_in` input.

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset, `busy`, `irq`, `sample_en` and `pwr_on` are low. Reading the control, select and result registers returns 0.
- R2: The register addresses are: control at 0, select at 1 (bits 2:0), and result at 2 (bits 9:0, other bits read 0). In the control register, bit 7 is run, bit 0 is enable and bit 1 is trigger mode. `pwr_on` is high when run or enable is set and `standby` is low. Enable alone starts nothing.
- R3: With run=1, enable=1 and trigger mode=0, a conversion starts at the clock edge that accepts the control or select write. In this mode conversions repeat back to back, one every 64 cycles.
- R4: `sample_en` is high for the first 8 cycles of a conversion. The next 10 cycles decide one bit each, MSB first, with `cmp_in`=1 meaning the input is at or above `dac_code`. The result equals the input level as a 10-bit code, and both 0 and 1023 convert exactly.
- R5: `irq` is a single-cycle pulse. It is high in the first cycle in which the new result can be read, which is 64 cycles after the start when there is no collision.
- R6: With run, enable and trigger mode all set, a rising edge on `ext_trig` starts exactly one conversion when the block is idle. `ext_trig` passes through a 2-flop synchronizer, so `busy` rises at the third clock edge after the pin goes high.
- R7: A trigger edge that arrives while a conversion runs is ignored, and this includes the end-of-conversion cycle.
- R8: A result read in the end-of-conversion cycle returns the old value. The new value and `irq` then appear one cycle later.
- R9: A control or select write in the end-of-conversion cycle leaves the result unchanged and suppresses `irq`.
- R10: A control or select write during a conversion aborts it. If the new settings still select software mode, a new conversion starts from sampling at the same edge.
- R11: `standby` stops a running conversion at the next edge, with no `irq`, and holds `pwr_on` low. In software mode, conversion resumes when `standby` falls.
- R12: `ch_sel` outputs the value of the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Chip standby; halts the converter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| ext_trig | input | 1 | Asynchronous external trigger |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | 10 | Trial code driven to the analog side |
| sample_en | output | 1 | Sampling window active |
| ch_sel | output | 3 | Selected input |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Conversion-end pulse |
| pwr_on | output | 1 | Analog section powered |

## Verification
The conversion path is tested with random input levels on random inputs, and the edge codes 0 and 1023 are added directly. Together these show that every bit decision is right, including MSB-first order and the at-or-above comparison sense. Directed collisions line up a read, a register write or a trigger edge with the exact end-of-conversion cycle. The read case checks that the old value is returned and that the load slips by one cycle. The write case checks that the load and the pulse are cancelled. The trigger case checks that the edge is dropped. Mid-conversion writes and standby check abort against restart. Back-to-back intervals between pulses check the continuous software mode.

// File: rtl/adcseq_pkg.sv
// Shared defaults and register encodings for the converter sequencer.
package adcseq_pkg;
    localparam int DEF_RES_W      = 10;
    localparam int DEF_CONV_LEN   = 64;
    localparam int DEF_SAMPLE_LEN = 8;
    localparam int DEF_CH_W       = 3;
    localparam int DEF_SYNC_STG   = 2;
    localparam int REG_W          = 8;
    localparam int DATA_W         = 16;
    localparam int ADDR_W         = 2;

    // Register addresses on the bus
    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_SEL  = 2'd1,
        A_RES  = 2'd2
    } reg_addr_e;

    // Control register bit positions
    localparam int CB_RUN  = 7;
    localparam int CB_EN   = 0;
    localparam int CB_TRIG = 1;
endpackage

// File: rtl/adcseq_trig_sync.sv
// Trigger synchronizer and rising-edge detector.
// Assumes async_in is a slow level; rise is a one-cycle pulse STAGES cycles late.
module adcseq_trig_sync #(
    parameter int STAGES = adcseq_pkg::DEF_SYNC_STG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // Shift the pin through the synchronizer chain plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adcseq_sar.sv
// Conversion timing and successive-approximation register.
// Assumes start and stop are never high together unless stop should win.
module adcseq_sar #(
    parameter int RES_W      = adcseq_pkg::DEF_RES_W,
    parameter int CONV_LEN   = adcseq_pkg::DEF_CONV_LEN,
    parameter int SAMPLE_LEN = adcseq_pkg::DEF_SAMPLE_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             repeat_en,
    input  logic             cmp_in,
    output logic             busy,
    output logic             eoc,
    output logic             sample_en,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] conv_val
);
    localparam int CNT_W = $clog2(CONV_LEN);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(CONV_LEN - 1);
    localparam logic [CNT_W-1:0] SMP_N  = CNT_W'(SAMPLE_LEN);
    localparam logic [CNT_W-1:0] DEC_HI = CNT_W'(SAMPLE_LEN + RES_W);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] dec_mask;
    logic             deciding;

    // Flag the cycles in which one bit is being decided
    assign deciding = busy_q && (cnt_q >= SMP_N) && (cnt_q < DEC_HI);

    // One-hot marker of the bit under trial, MSB first
    always_comb begin
        dec_mask = '0;
        for (int b = 0; b < RES_W; b++) begin
            if (deciding && (int'(cnt_q) - SAMPLE_LEN == RES_W - 1 - b))
                dec_mask[b] = 1'b1;
        end
    end

    // Sequence counter, run flag and bit decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            sar_q  <= '0;
        end else if (stop) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            sar_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= repeat_en;
                cnt_q  <= '0;
                sar_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                for (int b = 0; b < RES_W; b++) begin
                    if (dec_mask[b]) sar_q[b] <= cmp_in;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign eoc       = busy_q && (cnt_q == LAST);
    assign sample_en = busy_q && (cnt_q < SMP_N);
    assign dac_code  = sar_q | dec_mask;
    assign conv_val  = sar_q;
endmodule

// File: rtl/adcseq_result.sv
// Result register with end-of-conversion collision rules.
// A config write cancels the load; a result read defers it by a cycle.
module adcseq_result #(
    parameter int RES_W = adcseq_pkg::DEF_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoc,
    input  logic [RES_W-1:0] conv_val,
    input  logic             rd_hit,
    input  logic             cfg_wr,
    output logic [RES_W-1:0] res_q,
    output logic             pend,
    output logic             irq
);
    logic             pend_q;
    logic             irq_q;
    logic [RES_W-1:0] pend_val;
    logic [RES_W-1:0] res_r;
    logic [RES_W-1:0] load_val;

    // Choose between a fresh result and a deferred one
    assign load_val = eoc ? conv_val : pend_val;

    // Apply, defer or drop the result load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            pend_val <= '0;
            res_r    <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cfg_wr) begin
                pend_q <= 1'b0;
            end else if (eoc || pend_q) begin
                if (rd_hit) begin
                    pend_q   <= 1'b1;
                    pend_val <= load_val;
                end else begin
                    res_r  <= load_val;
                    irq_q  <= 1'b1;
                    pend_q <= 1'b0;
                end
            end
        end
    end

    assign res_q = res_r;
    assign pend  = pend_q;
    assign irq   = irq_q;
endmodule

// File: rtl/adcseq_ctrl.sv
// Top: bus registers, start/stop decisions and output mapping.
// Assumes single-cycle bus strobes; read data is valid in the strobe cycle.
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int RES_W      = DEF_RES_W,
    parameter int CONV_LEN   = DEF_CONV_LEN,
    parameter int SAMPLE_LEN = DEF_SAMPLE_LEN,
    parameter int CH_W       = DEF_CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_trig,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic              sample_en,
    output logic [CH_W-1:0]   ch_sel,
    output logic              busy,
    output logic              irq,
    output logic              pwr_on
);
    logic [REG_W-1:0] ctrl_q, ctrl_nxt;
    logic [CH_W-1:0]  sel_q;
    logic             wr_ctrl, wr_sel, cfg_wr, rd_res;
    logic             trig_rise, start, stop, eoc, pend;
    logic             soft_now, soft_nxt, trig_arm;
    logic [RES_W-1:0] conv_val, res_q;

    // Decode bus strobes
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_sel  = bus_wr && (bus_addr == A_SEL);
    assign cfg_wr  = wr_ctrl || wr_sel;
    assign rd_res  = bus_rd && (bus_addr == A_RES);
    assign ctrl_nxt = wr_ctrl ? bus_wdata : ctrl_q;

    // Control and select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_sel)  sel_q  <= bus_wdata[CH_W-1:0];
        end
    end

    // Mode qualifiers for current and incoming settings
    assign soft_now = ctrl_q[CB_RUN] && ctrl_q[CB_EN] && !ctrl_q[CB_TRIG];
    assign soft_nxt = ctrl_nxt[CB_RUN] && ctrl_nxt[CB_EN] && !ctrl_nxt[CB_TRIG];
    assign trig_arm = ctrl_q[CB_RUN] && ctrl_q[CB_EN] && ctrl_q[CB_TRIG];

    // Start and stop decisions
    always_comb begin
        stop  = standby || (cfg_wr && !soft_nxt);
        start = 1'b0;
        if (!standby) begin
            if (cfg_wr)
                start = soft_nxt;
            else if (!busy)
                start = soft_now || (trig_arm && trig_rise && !pend);
        end
    end

    adcseq_trig_sync #(.STAGES(DEF_SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .rise     (trig_rise)
    );

    adcseq_sar #(
        .RES_W      (RES_W),
        .CONV_LEN   (CONV_LEN),
        .SAMPLE_LEN (SAMPLE_LEN)
    ) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .repeat_en (soft_now),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .eoc       (eoc),
        .sample_en (sample_en),
        .dac_code  (dac_code),
        .conv_val  (conv_val)
    );

    adcseq_result #(.RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoc      (eoc),
        .conv_val (conv_val),
        .rd_hit   (rd_res),
        .cfg_wr   (cfg_wr),
        .res_q    (res_q),
        .pend     (pend),
        .irq      (irq)
    );

    // Read-data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_SEL:   bus_rdata = DATA_W'(sel_q);
            A_RES:   bus_rdata = DATA_W'(res_q);
            default: bus_rdata = '0;
        endcase
    end

    assign ch_sel = sel_q;
    assign pwr_on = (ctrl_q[CB_RUN] || ctrl_q[CB_EN]) && !standby;
endmodule

// File: rtl/adcseq_chk.sv
// Checker for the sequencer's port-level timing rules; bound to the top.
module adcseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       standby,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic       busy,
    input logic       irq,
    input logic       sample_en
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                             // R5
    AST_STANDBY_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !busy);                                        // R11
    AST_CFG_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr < 2'd2) |=> !irq);                     // R9
    AST_READ_DEFERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2) |=> !irq);                    // R8
    AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> busy);                                       // R4
    AST_START_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sample_en);                                // R10
endmodule

bind adcseq_ctrl adcseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .busy      (busy),
    .irq       (irq),
    .sample_en (sample_en)
);

// File: tb/tb_adcseq_ctrl.sv
module tb_adcseq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [15:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        cmp_in;
    logic [9:0]  dac_code;
    logic        sample_en, busy, irq, pwr_on;
    logic [2:0]  ch_sel;
    logic [9:0]  level [8];

    int n_checks = 0;
    int n_errs = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Comparator stub: input at or above the trial code
    assign cmp_in = (level[ch_sel] >= dac_code);

    adcseq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
        .cmp_in(cmp_in), .dac_code(dac_code), .sample_en(sample_en),
        .ch_sel(ch_sel), .busy(busy), .irq(irq), .pwr_on(pwr_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write strobe held for one cycle; returns at the negedge after the edge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Read outside any strobe-sensitive cycle (no collision intended)
    task automatic bus_peek(input logic [1:0] a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for irq; returns number of negedges waited
    task automatic wait_irq(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!irq && waited < 300);
    endtask

    function automatic int expect_code(input logic [9:0] lv);
        return int'(lv);
    endfunction

    initial begin
        int v, w, ch, seen;
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) level[i] = 10'(i * 100 + 7);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 pwr_on", int'(pwr_on), 0);
        chk("R1 sample_en", int'(sample_en), 0);
        bus_peek(2'd0, v); chk("R1 ctrl", v, 0);
        bus_peek(2'd1, v); chk("R1 sel", v, 0);
        bus_peek(2'd2, v); chk("R1 result", v, 0);

        // R2: enable alone powers up but starts nothing
        bus_write(2'd0, 8'h01);
        idle(5);
        chk("R2 pwr_on en", int'(pwr_on), 1);
        chk("R2 no start", int'(busy), 0);
        bus_peek(2'd0, v); chk("R2 ctrl readback", v, 8'h01);
        bus_write(2'd0, 8'h80);
        chk("R2 pwr_on run", int'(pwr_on), 1);
        bus_write(2'd0, 8'h00);
        chk("R2 pwr_on off", int'(pwr_on), 0);

        // R3/R4/R5/R12: directed software conversion
        level[3] = 10'h2A5;
        bus_write(2'd0, 8'h81);
        bus_write(2'd1, 8'd3);
        chk("R12 ch_sel", int'(ch_sel), 3);
        chk("R3 busy at start", int'(busy), 1);
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            if (sample_en) seen++;
            @(negedge clk);
        end
        chk("R4 sample cycles", seen, 8);
        chk("R4 sample ends", int'(sample_en), 0);
        wait_irq(w);
        chk("R5 latency", w + 8, 64);
        @(negedge clk);
        chk("R5 single pulse", int'(irq), 0);
        bus_peek(2'd2, v); chk("R4 result", v, 16'h2A5);
        wait_irq(w);
        chk("R3 repeat period", w + 1, 64);

        // R4: edge codes then random levels and inputs
        for (int it = 0; it < 24; it++) begin
            ch = int'($urandom_range(0, 7));
            if (it == 0)      level[ch] = 10'h000;
            else if (it == 1) level[ch] = 10'h3FF;
            else              level[ch] = 10'($urandom_range(0, 1023));
            bus_write(2'd1, 8'(ch));
            wait_irq(w);
            chk("R5 latency rnd", w, 64);
            @(negedge clk);
            bus_peek(2'd2, v);
            chk("R4 random code", v, expect_code(level[ch]));
        end

        // R8: read collides with the load
        level[5] = 10'h111;
        bus_write(2'd1, 8'd5);
        wait_irq(w);
        chk("R8 pre latency", w, 64);
        level[5] = 10'h222;
        idle(63);
        bus_rd = 1'b1; bus_addr = 2'd2;
        #1 chk("R8 old value read", int'(bus_rdata), 16'h111);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R8 irq deferred", int'(irq), 0);
        @(negedge clk);
        chk("R8 irq late", int'(irq), 1);
        bus_peek(2'd2, v); chk("R8 new value", v, 16'h222);

        // R9/R10: select write in the end cycle cancels load and restarts
        level[5] = 10'h333;
        bus_write(2'd1, 8'd5);
        idle(62);
        bus_write(2'd1, 8'd5);
        chk("R9 no irq", int'(irq), 0);
        chk("R10 restart sampling", int'(sample_en), 1);
        bus_peek(2'd2, v); chk("R9 result kept", v, 16'h222);
        wait_irq(w);
        chk("R10 restart latency", w, 64);
        bus_peek(2'd2, v); chk("R10 result after restart", v, 16'h333);

        // R10: mid-conversion abort
        level[2] = 10'h0F0;
        bus_write(2'd1, 8'd2);
        idle(29);
        bus_write(2'd1, 8'd2);
        wait_irq(w);
        chk("R10 abort latency", w, 64);
        bus_peek(2'd2, v); chk("R10 abort result", v, 16'h0F0);

        // R6/R7: trigger mode
        level[2] = 10'h1C3;
        bus_write(2'd0, 8'h83);
        idle(4);
        chk("R6 idle in trig mode", int'(busy), 0);
        ext_trig = 1'b1;
        @(negedge clk); chk("R6 sync n1", int'(busy), 0);
        @(negedge clk); chk("R6 sync n2", int'(busy), 0);
        @(negedge clk); chk("R6 start n3", int'(busy), 1);
        seen = 0;
        for (int k = 4; k <= 67; k++) begin
            @(negedge clk);
            if (k == 10) ext_trig = 1'b0;
            if (k == 20) ext_trig = 1'b1;
            if (k == 40) ext_trig = 1'b0;
            if (k == 64) ext_trig = 1'b1;
            if (irq) seen = k;
        end
        chk("R6 irq cycle", seen, 67);
        bus_peek(2'd2, v); chk("R6 trig result", v, 16'h1C3);
        seen = 0;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (irq || busy) seen++;
        end
        chk("R7 edges ignored", seen, 0);
        ext_trig = 1'b0;
        idle(4);
        level[2] = 10'h05A;
        ext_trig = 1'b1;
        wait_irq(w);
        chk("R6 second trigger", w, 67);
        bus_peek(2'd2, v); chk("R6 second result", v, 16'h05A);
        ext_trig = 1'b0;

        // R11: standby halts and resumes
        bus_write(2'd0, 8'h81);
        bus_write(2'd1, 8'd1);
        idle(20);
        standby = 1'b1;
        #1 chk("R11 pwr_on low", int'(pwr_on), 0);
        @(negedge clk);
        chk("R11 stopped", int'(busy), 0);
        seen = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (irq || busy) seen++;
        end
        chk("R11 quiet", seen, 0);
        standby = 1'b0;
        @(negedge clk);
        chk("R11 resume", int'(busy), 1);
        wait_irq(w);
        chk("R11 resume latency", w, 64);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule